// File: doc/BRIEF.md
# External Data Space Access Router

This block sits between a small 8-bit CPU core and its external-data-space accesses, the indirect load/store path used for bulk data. For each access it picks one of three targets: a 2 KB on-chip auxiliary SRAM held inside the block, a 2 KB read-only non-volatile data region, or the external memory bus. It can also turn the access into a silent no-operation.

The choice depends on several inputs together. Two mode bits select the mode: `nvm_en` has priority over `sram_en`. The CPU also tells the block whether the access is pointer-based (a full 16-bit address) or register-indirect (an 8-bit register value under an 8-bit page input), whether it is a read or a write, and whether the effective address lies inside the 2 KB region at 0x0000–0x07FF.

SRAM, non-volatile and no-operation accesses finish at the clock edge where the request is sampled. External accesses keep the request asserted until the external bus reports ready. A busy flag from the non-volatile programming controller marks non-volatile read data as invalid.

Top module: `movx_router`

## Requirements
- R1: After reset, `acc_done`, `nop_done` and `rd_invalid` are 0 and `rd_data` is 0xFF.
- R2: With `nvm_en`=0 and `sram_en`=0, every read and write selects the external bus (`sel_ext`=1, `ext_we`=`acc_wr`, `ext_addr` = effective address). A read returns the `ext_rdata` sampled at the completing edge.
- R3: With `nvm_en`=0 and `sram_en`=1, reads and writes at 0x0000–0x07FF select the SRAM. A read returns the last byte written to that address.
- R4: With `nvm_en`=0 and `sram_en`=1, accesses at 0x0800 and above select the external bus.
- R5: With `nvm_en`=1, `sram_en` has no effect. A read at 0x0000–0x07FF, pointer-based or register-indirect, selects the non-volatile region and returns `nvm_pattern(a)` = ({a[4:0],a[7:5]} XOR a[15:8]) + 0x5A.
- R6: With `nvm_en`=1, a pointer-based read at 0x0800 or above selects the external bus.
- R7: With `nvm_en`=1, a register-indirect read at 0x0800 or above is a no-operation.
- R8: With `nvm_en`=1, a pointer-based write inside the region is a no-operation and one above it selects the external bus. A register-indirect write is a no-operation at every address. No write ever reaches the SRAM in this mode.
- R9: A no-operation gives `acc_done` and `nop_done` for one cycle after the completing edge, returns `rd_data`=0xFF, selects no target, and changes no memory.
- R10: A non-volatile read made while `nvm_busy`=1 sets `rd_invalid`. The next completed access without that condition clears it.
- R11: The address is `acc_addr` when `acc_ptr`=1. When `acc_ptr`=0 it is {`page_hi`,`acc_reg`}.
- R12: An external access does not complete, and `acc_done` stays 0, while `ext_ready` is 0. It completes at the first edge with `ext_ready`=1.
- R13: With `acc_req`=0, no target select is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_req | input | 1 | Access request, held until completion |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_ptr | input | 1 | 1 = pointer-based 16-bit address, 0 = register-indirect |
| acc_addr | input | 16 | Pointer address |
| acc_reg | input | 8 | Register value for register-indirect access |
| page_hi | input | 8 | Upper address byte for register-indirect access |
| acc_wdata | input | 8 | Write data |
| nvm_en | input | 1 | Non-volatile read mode enable (priority) |
| sram_en | input | 1 | Auxiliary SRAM enable |
| nvm_busy | input | 1 | Non-volatile erase/program controller busy |
| ext_ready | input | 1 | External bus ready |
| ext_rdata | input | 8 | External read data |
| sel_sram | output | 1 | SRAM is the current target |
| sel_nvm | output | 1 | Non-volatile region is the current target |
| sel_ext | output | 1 | External bus is the current target |
| ext_we | output | 1 | External write strobe |
| ext_addr | output | 16 | Effective address |
| ext_wdata | output | 8 | External write data |
| rd_data | output | 8 | Read data of the last completed access |
| acc_done | output | 1 | Access completed at the previous edge |
| nop_done | output | 1 | The completed access was a no-operation |
| rd_invalid | output | 1 | Last non-volatile read data is invalid |

## Verification
The target selects, `ext_we` and `ext_addr` are combinational, so the bench samples them shortly after it drives an access and before the next clock edge. `acc_done`, `nop_done`, `rd_data` and `rd_invalid` are registered and change at the edge that completes the access. The bench samples them at the next falling edge, with the request already withdrawn. The one-cycle width of `nop_done` is checked one falling edge later. For the external wait, `acc_done` is sampled at each falling edge while `ext_ready` is low, and then once more after the first edge with ready high.

// File: rtl/movx_pkg.sv
package movx_pkg;

  typedef enum logic [2:0] {
    TGT_IDLE,
    TGT_SRAM,
    TGT_NVM,
    TGT_EXT,
    TGT_NOP
  } tgt_e;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_SRAM,
    SRC_NVM,
    SRC_EXT
  } src_e;

  // Target choice from mode bits, addressing form, direction and region hit.
  function automatic tgt_e route(input logic nvm_on, input logic sram_on,
                                 input logic ptr, input logic wr,
                                 input logic in_rgn);
    if (nvm_on) begin
      if (!wr) begin
        if (in_rgn) return TGT_NVM;
        return ptr ? TGT_EXT : TGT_NOP;
      end
      return (ptr && !in_rgn) ? TGT_EXT : TGT_NOP;
    end
    if (sram_on) return in_rgn ? TGT_SRAM : TGT_EXT;
    return TGT_EXT;
  endfunction

  // Contents of the read-only non-volatile region.
  function automatic logic [7:0] nvm_pattern(input logic [15:0] a);
    return ({a[4:0], a[7:5]} ^ a[15:8]) + 8'h5A;
  endfunction

endpackage

// File: rtl/movx_decode.sv
module movx_decode
  import movx_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int REGION_BYTES = 2048
) (
  input  logic                     acc_req,
  input  logic                     acc_wr,
  input  logic                     acc_ptr,
  input  logic [ADDR_W-1:0]        acc_addr,
  input  logic [DATA_W-1:0]        acc_reg,
  input  logic [ADDR_W-DATA_W-1:0] page_hi,
  input  logic                     nvm_en,
  input  logic                     sram_en,
  output logic [ADDR_W-1:0]        eff_addr,
  output logic                     in_region,
  output tgt_e                     tgt
);

  localparam logic [ADDR_W-1:0] REGION_END = ADDR_W'(REGION_BYTES);

  always_comb begin
    eff_addr  = acc_ptr ? acc_addr : {page_hi, acc_reg};
    in_region = (eff_addr < REGION_END);
    tgt       = acc_req ? route(nvm_en, sram_en, acc_ptr, acc_wr, in_region)
                        : TGT_IDLE;
  end

endmodule

// File: rtl/movx_aux_sram.sv
module movx_aux_sram #(
  parameter int DEPTH  = 2048,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] idx,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '1;
    else if (re) rdata <= mem[idx];
  end

  AST_SRAM_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && re)); // R3

endmodule

// File: rtl/movx_nvm_rom.sv
module movx_nvm_rom
  import movx_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] rdata
);

  logic [15:0] a16;
  assign a16 = 16'(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '1;
    else if (re) rdata <= DATA_W'(nvm_pattern(a16));
  end

endmodule

// File: rtl/movx_router.sv
module movx_router
  import movx_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int REGION_BYTES = 2048
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc_req,
  input  logic                     acc_wr,
  input  logic                     acc_ptr,
  input  logic [ADDR_W-1:0]        acc_addr,
  input  logic [DATA_W-1:0]        acc_reg,
  input  logic [ADDR_W-DATA_W-1:0] page_hi,
  input  logic [DATA_W-1:0]        acc_wdata,
  input  logic                     nvm_en,
  input  logic                     sram_en,
  input  logic                     nvm_busy,
  input  logic                     ext_ready,
  input  logic [DATA_W-1:0]        ext_rdata,
  output logic                     sel_sram,
  output logic                     sel_nvm,
  output logic                     sel_ext,
  output logic                     ext_we,
  output logic [ADDR_W-1:0]        ext_addr,
  output logic [DATA_W-1:0]        ext_wdata,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     acc_done,
  output logic                     nop_done,
  output logic                     rd_invalid
);

  localparam int IDX_W = $clog2(REGION_BYTES);

  logic [ADDR_W-1:0] eff_addr;
  logic              in_region;
  tgt_e              tgt;
  logic              sel_nop;
  logic              complete;
  logic              sram_we, sram_re;
  logic [DATA_W-1:0] sram_q, nvm_q, ext_q;
  src_e              src_q;

  movx_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REGION_BYTES(REGION_BYTES)
  ) u_dec (
    .acc_req  (acc_req),
    .acc_wr   (acc_wr),
    .acc_ptr  (acc_ptr),
    .acc_addr (acc_addr),
    .acc_reg  (acc_reg),
    .page_hi  (page_hi),
    .nvm_en   (nvm_en),
    .sram_en  (sram_en),
    .eff_addr (eff_addr),
    .in_region(in_region),
    .tgt      (tgt)
  );

  assign sel_sram  = (tgt == TGT_SRAM);
  assign sel_nvm   = (tgt == TGT_NVM);
  assign sel_ext   = (tgt == TGT_EXT);
  assign sel_nop   = (tgt == TGT_NOP);
  assign complete  = acc_req && (!sel_ext || ext_ready);
  assign sram_we   = sel_sram && acc_wr;
  assign sram_re   = sel_sram && !acc_wr;
  assign ext_we    = sel_ext && acc_wr;
  assign ext_addr  = eff_addr;
  assign ext_wdata = acc_wdata;

  movx_aux_sram #(.DEPTH(REGION_BYTES), .DATA_W(DATA_W)) u_sram (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (sram_we),
    .re   (sram_re),
    .idx  (eff_addr[IDX_W-1:0]),
    .wdata(acc_wdata),
    .rdata(sram_q)
  );

  movx_nvm_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_nvm (
    .clk  (clk),
    .rst_n(rst_n),
    .re   (sel_nvm),
    .addr (eff_addr),
    .rdata(nvm_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_done   <= 1'b0;
      nop_done   <= 1'b0;
      rd_invalid <= 1'b0;
      src_q      <= SRC_NONE;
      ext_q      <= '1;
    end else begin
      acc_done <= complete;
      nop_done <= complete && sel_nop;
      if (complete) begin
        rd_invalid <= sel_nvm && nvm_busy;
        if (sel_nop)                  src_q <= SRC_NONE;
        else if (sram_re)             src_q <= SRC_SRAM;
        else if (sel_nvm)             src_q <= SRC_NVM;
        else if (sel_ext && !acc_wr) begin
          src_q <= SRC_EXT;
          ext_q <= ext_rdata;
        end
      end
    end
  end

  always_comb begin
    unique case (src_q)
      SRC_SRAM: rd_data = sram_q;
      SRC_NVM:  rd_data = nvm_q;
      SRC_EXT:  rd_data = ext_q;
      default:  rd_data = '1;
    endcase
  end

  AST_IDLE_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_req |-> !(sel_sram || sel_nvm || sel_ext)); // R13
  AST_NVM_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && acc_wr && nvm_en) |-> !sram_we); // R8
  AST_NVM_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    sel_nvm |-> !acc_wr); // R5
  AST_EXT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && sel_ext && !ext_ready) |=> !acc_done); // R12
  AST_NOP_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
    nop_done |-> (acc_done && rd_data == '1)); // R9
  AST_INVALID_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_invalid) |-> $past(sel_nvm && nvm_busy)); // R10
  AST_SRAM_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    sel_sram |-> (ext_addr < ADDR_W'(REGION_BYTES))); // R3

endmodule

// File: tb/sim_movx_router.sv
module sim_movx_router;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_req, acc_wr, acc_ptr;
  logic [15:0] acc_addr;
  logic [7:0]  acc_reg, page_hi, acc_wdata;
  logic        nvm_en, sram_en, nvm_busy, ext_ready;
  logic [7:0]  ext_rdata;
  logic        sel_sram, sel_nvm, sel_ext, ext_we;
  logic [15:0] ext_addr;
  logic [7:0]  ext_wdata, rd_data;
  logic        acc_done, nop_done, rd_invalid;

  int total = 0;
  int bad   = 0;

  // snapshots taken by the access helper
  logic        s_sram, s_nvm, s_ext, s_we;
  logic [15:0] s_addr;
  logic        s_done, s_nop, s_inv;
  logic [7:0]  s_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  movx_router u0 (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_wr(acc_wr),
    .acc_ptr(acc_ptr), .acc_addr(acc_addr), .acc_reg(acc_reg),
    .page_hi(page_hi), .acc_wdata(acc_wdata), .nvm_en(nvm_en),
    .sram_en(sram_en), .nvm_busy(nvm_busy), .ext_ready(ext_ready),
    .ext_rdata(ext_rdata), .sel_sram(sel_sram), .sel_nvm(sel_nvm),
    .sel_ext(sel_ext), .ext_we(ext_we), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .rd_data(rd_data), .acc_done(acc_done),
    .nop_done(nop_done), .rd_invalid(rd_invalid)
  );

  // Expected non-volatile byte, written as rotate/shift arithmetic.
  function automatic logic [7:0] exp_nvm(input logic [15:0] a);
    int lo, hi, rot;
    lo  = a & 16'h00FF;
    hi  = (a >> 8) & 8'hFF;
    rot = ((lo << 3) | (lo >> 5)) & 8'hFF;
    return 8'((rot ^ hi) + 90);
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic ptr, input logic [15:0] a,
                        input logic [7:0] pg, input logic [7:0] rg,
                        input logic [7:0] wd);
    @(negedge clk);
    acc_wr = wr; acc_ptr = ptr; acc_addr = a; page_hi = pg; acc_reg = rg;
    acc_wdata = wd; acc_req = 1'b1;
    #1;
    s_sram = sel_sram; s_nvm = sel_nvm; s_ext = sel_ext; s_we = ext_we;
    s_addr = ext_addr;
    @(negedge clk);
    acc_req = 1'b0;
    #1;
    s_done = acc_done; s_nop = nop_done; s_rd = rd_data; s_inv = rd_invalid;
  endtask

  task automatic t_reset;
    chk(acc_done == 1'b0, "R1 acc_done", acc_done, 0);
    chk(nop_done == 1'b0, "R1 nop_done", nop_done, 0);
    chk(rd_invalid == 1'b0, "R1 rd_invalid", rd_invalid, 0);
    chk(rd_data == 8'hFF, "R1 rd_data", rd_data, 8'hFF);
    chk(!(sel_sram || sel_nvm || sel_ext), "R13 idle selects",
        {sel_sram, sel_nvm, sel_ext}, 0);
  endtask

  task automatic t_ext_mode;
    nvm_en = 0; sram_en = 0; ext_rdata = 8'hC3;
    access(1'b0, 1'b1, 16'h0123, 8'h00, 8'h00, 8'h00);
    chk(s_ext && !s_we && s_addr == 16'h0123, "R2 ptr read select",
        {s_ext, s_we, s_addr}, {1'b1, 1'b0, 16'h0123});
    chk(s_done && s_rd == 8'hC3, "R2 ext read data", s_rd, 8'hC3);
    access(1'b1, 1'b0, 16'hFFFF, 8'h12, 8'h34, 8'h9E);
    chk(s_ext && s_we && s_addr == 16'h1234, "R11 reg-indirect ext write",
        s_addr, 16'h1234);
    chk(ext_wdata == 8'h9E, "R2 ext_wdata", ext_wdata, 8'h9E);
  endtask

  task automatic t_ext_wait;
    nvm_en = 0; sram_en = 0; ext_ready = 0; ext_rdata = 8'h5C;
    @(negedge clk);
    acc_wr = 0; acc_ptr = 1; acc_addr = 16'h4000; acc_req = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk(acc_done == 1'b0, "R12 no done while not ready", acc_done, 0);
    end
    ext_ready = 1;
    @(negedge clk);
    acc_req = 0;
    #1;
    chk(acc_done == 1'b1 && rd_data == 8'h5C, "R12 done after ready",
        {acc_done, rd_data}, {1'b1, 8'h5C});
  endtask

  task automatic t_sram;
    nvm_en = 0; sram_en = 1;
    access(1'b1, 1'b1, 16'h0010, 8'h00, 8'h00, 8'hA5);
    chk(s_sram && !s_ext, "R3 sram write select", {s_sram, s_ext}, 2'b10);
    access(1'b1, 1'b1, 16'h07FF, 8'h00, 8'h00, 8'h3C);
    access(1'b1, 1'b0, 16'h0000, 8'h05, 8'h20, 8'h77);
    access(1'b0, 1'b1, 16'h0010, 8'h00, 8'h00, 8'h00);
    chk(s_sram && s_rd == 8'hA5, "R3 read 0x0010", s_rd, 8'hA5);
    access(1'b0, 1'b1, 16'h07FF, 8'h00, 8'h00, 8'h00);
    chk(s_rd == 8'h3C, "R3 read top of region", s_rd, 8'h3C);
    access(1'b0, 1'b1, 16'h0520, 8'h00, 8'h00, 8'h00);
    chk(s_rd == 8'h77, "R11 reg-indirect sram write", s_rd, 8'h77);
    access(1'b0, 1'b1, 16'h0800, 8'h00, 8'h00, 8'h00);
    chk(s_ext && !s_sram, "R4 0x0800 goes external", {s_sram, s_ext}, 2'b01);
    access(1'b1, 1'b0, 16'h0000, 8'h20, 8'h00, 8'h11);
    chk(s_ext && s_we && s_addr == 16'h2000, "R4 reg-indirect above region",
        s_addr, 16'h2000);
  endtask

  task automatic t_nvm_reads;
    nvm_en = 1; sram_en = 1; nvm_busy = 0;
    access(1'b0, 1'b1, 16'h0010, 8'h00, 8'h00, 8'h00);
    chk(s_nvm && !s_sram && s_rd == exp_nvm(16'h0010), "R5 ptr nvm read",
        s_rd, exp_nvm(16'h0010));
    access(1'b0, 1'b0, 16'h0000, 8'h07, 8'hFF, 8'h00);
    chk(s_nvm && s_rd == exp_nvm(16'h07FF), "R5 reg-indirect nvm read",
        s_rd, exp_nvm(16'h07FF));
    sram_en = 0;
    access(1'b0, 1'b1, 16'h0321, 8'h00, 8'h00, 8'h00);
    chk(s_nvm && s_rd == exp_nvm(16'h0321), "R5 sram_en ignored",
        s_rd, exp_nvm(16'h0321));
    ext_rdata = 8'h6D;
    access(1'b0, 1'b1, 16'h0800, 8'h00, 8'h00, 8'h00);
    chk(s_ext && s_rd == 8'h6D, "R6 ptr read above region", s_rd, 8'h6D);
    access(1'b0, 1'b0, 16'h0000, 8'h08, 8'h00, 8'h00);
    chk(!(s_sram || s_nvm || s_ext) && s_nop && s_done && s_rd == 8'hFF,
        "R7 reg-indirect read above region is nop", {s_nop, s_rd}, {1'b1, 8'hFF});
    @(negedge clk); #1;
    chk(nop_done == 1'b0, "R9 nop_done one cycle", nop_done, 0);
  endtask

  task automatic t_nvm_writes;
    nvm_en = 1; sram_en = 1;
    access(1'b1, 1'b1, 16'h0010, 8'h00, 8'h00, 8'h11);
    chk(s_nop && !(s_sram || s_ext), "R8 ptr write in region nop",
        {s_nop, s_sram, s_ext}, 3'b100);
    access(1'b1, 1'b1, 16'h9000, 8'h00, 8'h00, 8'h22);
    chk(s_ext && s_we && !s_nop, "R8 ptr write above region external",
        {s_ext, s_we}, 2'b11);
    access(1'b1, 1'b0, 16'h0000, 8'h00, 8'h10, 8'h33);
    chk(s_nop && !s_ext, "R8 reg-indirect write in region nop", s_nop, 1);
    access(1'b1, 1'b0, 16'h0000, 8'h40, 8'h00, 8'h44);
    chk(s_nop && !s_ext && s_rd == 8'hFF, "R8 reg-indirect write above nop",
        {s_nop, s_ext}, 2'b10);
    nvm_en = 0; sram_en = 1;
    access(1'b0, 1'b1, 16'h0010, 8'h00, 8'h00, 8'h00);
    chk(s_rd == 8'hA5, "R9 sram unchanged by nop writes", s_rd, 8'hA5);
  endtask

  task automatic t_busy;
    nvm_en = 1; nvm_busy = 1;
    access(1'b0, 1'b1, 16'h0042, 8'h00, 8'h00, 8'h00);
    chk(s_inv == 1'b1, "R10 invalid while busy", s_inv, 1);
    nvm_busy = 0;
    access(1'b0, 1'b1, 16'h0043, 8'h00, 8'h00, 8'h00);
    chk(s_inv == 1'b0 && s_rd == exp_nvm(16'h0043), "R10 cleared next read",
        {s_inv, s_rd}, {1'b0, exp_nvm(16'h0043)});
    nvm_busy = 1;
    access(1'b0, 1'b0, 16'h0000, 8'h09, 8'h00, 8'h00);
    chk(s_inv == 1'b0 && s_nop, "R10 nop while busy not invalid", s_inv, 0);
    nvm_busy = 0;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; acc_req = 0; acc_wr = 0; acc_ptr = 1; acc_addr = 0;
    acc_reg = 0; page_hi = 0; acc_wdata = 0; nvm_en = 0; sram_en = 0;
    nvm_busy = 0; ext_ready = 1; ext_rdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    t_reset();
    t_ext_mode();
    t_ext_wait();
    t_sram();
    t_nvm_reads();
    t_nvm_writes();
    t_busy();
    @(negedge clk); #1;
    chk(!(sel_sram || sel_nvm || sel_ext), "R13 idle selects at end",
        {sel_sram, sel_nvm, sel_ext}, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule